// File: doc/BRIEF.md
# Reloadable Up/Down Timer with Event Capture

This block is a 16-bit general-purpose timer peripheral that sits on a simple single-cycle register bus. Software sets it up through a control register. It chooses which of four tick-enable inputs advances the counter and whether the counter counts up or down. It also chooses between a free-running mode, where the counter wraps, and a periodic mode, where the counter reloads from a programmable load value on every timeout. A timeout raises a pending flag and the interrupt output, and software clears both through a write-only clear register. In periodic mode, that clear can optionally also restart the count from the load value.

The timer can also timestamp external activity. When capture is enabled, a rising edge on one selected line of sixteen event inputs copies the current count into a capture register and sets a capture-pending status bit. The live count is read back through a two-stage synchroniser delay, which models a count that crosses from a slower clock domain. The clock sources themselves are modelled as tick-enable inputs in the single bus-clock domain.

Top module: `gp_updown_timer`

## Requirements
- R1: After reset the control register reads 0x000A and every other register reads 0x0000. Control bits [15:13] always read as zero.
- R2: When enable (control bit 2) is 1, each cycle in which the tick input selected by control bits [6:5] (value n picks tick_src[n]) is high moves the counter by one. It counts up when control bit 1 is 1 and down when it is 0.
- R3: When control bit 2 is 0 the counter keeps its value whatever the tick inputs do.
- R4: A timeout is a tick that finds the counter at 0xFFFF when counting up, or at 0x0000 when counting down. With control bit 3 at 0 the counter wraps to 0x0000 or 0xFFFF. With control bit 3 at 1 it takes the load value.
- R5: A timeout sets status bit 0 and drives irq high from the next cycle. Writing 1 to bit 0 at offset 0x0C clears both. When a timeout and a clear fall in the same cycle, the timeout wins.
- R6: A write to the load register in the same cycle as a timeout takes effect one cycle later. The reload caused by that timeout uses the previous load value.
- R7: With control bits 3 and 7 both 1, writing 1 to bit 0 of the clear register also loads the counter from the load value, and this overrides any tick in that cycle. With either bit at 0, the write leaves the count alone.
- R8: With control bit 12 set, a rising edge on evt_in[k], where k is control bits [11:8], stores the pre-edge count in the capture register and sets status bit 1. A read of the capture register clears status bit 1, and a capture in the same cycle wins.
- R9: An event line held high gives exactly one capture. Edges on unselected lines, or any edge while control bit 12 is 0, change neither the capture register nor status bit 1.
- R10: The value register at offset 0x04 returns the counter value from two cycles before the read is issued.
- R11: Offsets are: load 0x00, value 0x04, control 0x08, clear 0x0C, capture 0x10, status 0x1C. Read data is registered and appears the cycle after the read. Unmapped offsets and the clear register read 0. Writes to value, capture and status have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tick_src | input | 4 | Four count-enable sources |
| evt_in | input | 16 | Event lines for capture |
| irq | output | 1 | Timeout interrupt, high while pending |

## Verification
A wrong count shows up at the value register exactly three cycles after the faulty edge: two synchroniser stages plus the registered read. It stays visible on every later read, because the error carries forward through each following step. A bad timeout or reload decision appears one cycle later on irq and then in the count readback. A bad capture or flag appears on the next read of the capture or status register. The reference model checks irq and the read data on every cycle, so any such divergence is reported within a few cycles of its cause.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int EVT_SEL_W = 4;
  localparam int SRC_SEL_W = 2;
  localparam int N_EVT     = 1 << EVT_SEL_W;
  localparam int N_SRC     = 1 << SRC_SEL_W;
  localparam int CTL_W     = 13;
  localparam logic [CTL_W-1:0] CTL_RST = 13'h000A;

  localparam logic [ADDR_W-1:0] OFS_LOAD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_VAL  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTL  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CAP  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h1C;

  // Field order is the bit layout of the control word (MSB first).
  typedef struct packed {
    logic                 cap_en;    // 12
    logic [EVT_SEL_W-1:0] evt_sel;   // 11:8
    logic                 rld;       // 7
    logic [SRC_SEL_W-1:0] src_sel;   // 6:5
    logic                 spare4;    // 4
    logic                 periodic;  // 3
    logic                 enable;    // 2
    logic                 count_up;  // 1
    logic                 spare0;    // 0
  } ctl_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= '0;
          else     stage[0] <= d;
        end
        p_stage_r10: assert property (@(posedge clk) disable iff (rst)
          1'b1 |=> stage[0] == $past(d));
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= '0;
          else     stage[i] <= stage[i-1];
        end
        p_chain_r10: assert property (@(posedge clk) disable iff (rst)
          1'b1 |=> stage[i] == $past(stage[i-1]));
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_t             ctl,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr_reload,
  input  logic [N_SRC-1:0] tick_src,
  output logic [CNT_W-1:0] cnt,
  output logic             timeout
);
  logic             tick;
  logic             at_end;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] wrap_val;

  assign tick     = ctl.enable & tick_src[ctl.src_sel];
  assign at_end   = ctl.count_up ? (cnt == {CNT_W{1'b1}}) : (cnt == '0);
  assign wrap_val = ctl.count_up ? '0 : {CNT_W{1'b1}};
  assign timeout  = tick & at_end & ~clr_reload;

  always_comb begin
    cnt_d = cnt;
    if (clr_reload) begin
      cnt_d = load_val;
    end else if (tick) begin
      if (at_end)            cnt_d = ctl.periodic ? load_val : wrap_val;
      else if (ctl.count_up) cnt_d = cnt + 1'b1;
      else                   cnt_d = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_d;
  end

  p_hold_off_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctl.enable && !clr_reload) |=> $stable(cnt));
  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr_reload && ctl.count_up && cnt != {CNT_W{1'b1}})
      |=> cnt == $past(cnt) + 1'b1);
  p_step_dn_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr_reload && !ctl.count_up && cnt != '0)
      |=> cnt == $past(cnt) - 1'b1);
  p_periodic_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (timeout && ctl.periodic) |=> cnt == $past(load_val));
  p_clear_reload_r7: assert property (@(posedge clk) disable iff (rst)
    clr_reload |=> cnt == $past(load_val));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_EVT-1:0]     evt_in,
  input  logic                 cap_en,
  input  logic [EVT_SEL_W-1:0] evt_sel,
  input  logic [CNT_W-1:0]     cnt,
  output logic [CNT_W-1:0]     cap_q,
  output logic                 cap_hit
);
  logic [N_EVT-1:0] evt_prev;
  logic [N_EVT-1:0] evt_rise;
  logic             past_ok;

  assign evt_rise = evt_in & ~evt_prev;
  assign cap_hit  = cap_en & evt_rise[evt_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_prev <= '0;
      cap_q    <= '0;
      past_ok  <= 1'b0;
    end else begin
      evt_prev <= evt_in;
      past_ok  <= 1'b1;
      if (cap_hit) cap_q <= cnt;
    end
  end

  p_cap_value_r8: assert property (@(posedge clk) disable iff (rst)
    cap_hit |=> cap_q == $past(cnt));
  p_cap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cap_hit |=> $stable(cap_q));
  p_level_once_r9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $stable(evt_sel) && evt_in[evt_sel] && $past(evt_in[evt_sel]))
      |-> !cap_hit);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              timeout,
  input  logic              cap_hit,
  input  logic [CNT_W-1:0]  cap_q,
  input  logic [CNT_W-1:0]  cnt_sync,
  output ctl_t              ctl,
  output logic [CNT_W-1:0]  load_val,
  output logic              clr_reload,
  output logic              irq
);
  logic             wr_en, rd_en;
  logic             wr_load, wr_ctl, clr_req;
  logic [CNT_W-1:0] pend_val;
  logic             pend_v;
  logic             to_flag, cap_flag;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en      = bus_sel & bus_wr;
  assign rd_en      = bus_sel & ~bus_wr;
  assign wr_load    = wr_en & (bus_addr == OFS_LOAD);
  assign wr_ctl     = wr_en & (bus_addr == OFS_CTL);
  assign clr_req    = wr_en & (bus_addr == OFS_CLR) & bus_wdata[0];
  assign clr_reload = clr_req & ctl.periodic & ctl.rld;
  assign irq        = to_flag;

  // Load value: a write landing on a timeout waits one cycle in pend_val.
  always_ff @(posedge clk) begin
    if (rst) begin
      load_val <= '0;
      pend_val <= '0;
      pend_v   <= 1'b0;
    end else begin
      if (pend_v) begin
        load_val <= pend_val;
        pend_v   <= 1'b0;
      end
      if (wr_load) begin
        if (timeout) begin
          pend_val <= bus_wdata[CNT_W-1:0];
          pend_v   <= 1'b1;
        end else begin
          load_val <= bus_wdata[CNT_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         ctl <= ctl_t'(CTL_RST);
    else if (wr_ctl) ctl <= ctl_t'(bus_wdata[CTL_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      to_flag  <= 1'b0;
      cap_flag <= 1'b0;
    end else begin
      if (timeout)      to_flag <= 1'b1;
      else if (clr_req) to_flag <= 1'b0;
      if (cap_hit)                                cap_flag <= 1'b1;
      else if (rd_en && bus_addr == OFS_CAP)      cap_flag <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_LOAD: rd_mux = DATA_W'(load_val);
      OFS_VAL:  rd_mux = DATA_W'(cnt_sync);
      OFS_CTL:  rd_mux = DATA_W'(ctl);
      OFS_CAP:  rd_mux = DATA_W'(cap_q);
      OFS_STAT: rd_mux = DATA_W'({cap_flag, to_flag});
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

  p_irq_set_r5: assert property (@(posedge clk) disable iff (rst)
    timeout |=> irq);
  p_irq_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !timeout) |=> !irq);
  p_load_defer_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_load && timeout && !pend_v) |=> $stable(load_val));
  p_capflag_r8: assert property (@(posedge clk) disable iff (rst)
    cap_hit |=> cap_flag);
  p_read_ctl_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr == OFS_CTL) |=> bus_rdata[15:13] == 3'b000);
endmodule

// File: rtl/gp_updown_timer.sv
module gp_updown_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  tick_src,
  input  logic [N_EVT-1:0]  evt_in,
  output logic              irq
);
  ctl_t             ctl;
  logic [CNT_W-1:0] load_val, cnt, cnt_sync, cap_q;
  logic             clr_reload, timeout, cap_hit;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .timeout, .cap_hit, .cap_q, .cnt_sync, .ctl, .load_val, .clr_reload, .irq
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst, .ctl, .load_val, .clr_reload, .tick_src, .cnt, .timeout
  );

  tmr_capture #(.CNT_W(CNT_W)) u_cap (
    .clk, .rst, .evt_in, .cap_en(ctl.cap_en), .evt_sel(ctl.evt_sel),
    .cnt, .cap_q, .cap_hit
  );

  tmr_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst, .d(cnt), .q(cnt_sync)
  );
endmodule

// File: tb/gp_updown_timer_test.sv
module gp_updown_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  tick_src = '0;
  logic [15:0] evt_in = '0;
  logic        irq;

  int    checks = 0, errors = 0, cycles = 0;
  string cur_tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  gp_updown_timer uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [15:0] m_ld, m_pend, m_ctl, m_cnt, m_s1, m_s2, m_cap, m_prev, m_rd;
  logic        m_pv, m_to, m_cp;
  logic [15:0] n_cnt;
  logic        tk, tmo, endv, clr, rdop, wrop;

  always @(posedge clk) begin
    if (rst) begin
      m_ld = 0; m_pend = 0; m_pv = 0; m_ctl = 16'h000A; m_cnt = 0;
      m_s1 = 0; m_s2 = 0; m_cap = 0; m_prev = 0; m_rd = 0; m_to = 0; m_cp = 0;
    end else begin
      wrop = bus_sel && bus_wr;
      rdop = bus_sel && !bus_wr;
      tk   = m_ctl[2] && tick_src[m_ctl[6:5]];
      endv = m_ctl[1] ? (m_cnt == 16'hFFFF) : (m_cnt == 0);
      clr  = wrop && bus_addr == 5'h0C && bus_wdata[0];
      tmo  = 0;
      n_cnt = m_cnt;
      if (clr && m_ctl[3] && m_ctl[7]) n_cnt = m_ld;
      else if (tk) begin
        if (endv) begin
          tmo = 1;
          n_cnt = m_ctl[3] ? m_ld : (m_ctl[1] ? 16'h0000 : 16'hFFFF);
        end else n_cnt = m_ctl[1] ? m_cnt + 1 : m_cnt - 1;
      end
      if (rdop) begin
        case (bus_addr)
          5'h00: m_rd = m_ld;
          5'h04: m_rd = m_s2;
          5'h08: m_rd = m_ctl;
          5'h10: m_rd = m_cap;
          5'h1C: m_rd = {14'd0, m_cp, m_to};
          default: m_rd = 0;
        endcase
      end
      if (m_pv) begin m_ld = m_pend; m_pv = 0; end
      if (wrop && bus_addr == 5'h00) begin
        if (tmo) begin m_pend = bus_wdata; m_pv = 1; end
        else m_ld = bus_wdata;
      end
      if (m_ctl[12] && evt_in[m_ctl[11:8]] && !m_prev[m_ctl[11:8]]) begin
        m_cap = m_cnt; m_cp = 1;
      end else if (rdop && bus_addr == 5'h10) m_cp = 0;
      if (tmo) m_to = 1; else if (clr) m_to = 0;
      if (wrop && bus_addr == 5'h08) m_ctl = bus_wdata & 16'h1FFF;
      m_prev = evt_in;
      m_s2 = m_s1; m_s1 = m_cnt;
      m_cnt = n_cnt;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected <= %0d)", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (!rst) begin
      checks++;
      if (irq !== m_to) begin
        errors++;
        $display("FAIL R5 irq: actual %0b expected %0b", irq, m_to);
      end
      checks++;
      if (bus_rdata !== m_rd) begin
        errors++;
        $display("FAIL %s read data: actual %h expected %h", cur_tag, bus_rdata, m_rd);
      end
    end
  end

  task automatic cyc(input logic s, input logic w, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    cyc(1, 1, a, d);
  endtask

  // Directed read against a hand-computed value
  task automatic rd_lit(input logic [4:0] a, input logic [15:0] exp, input string tag);
    cyc(1, 0, a, 0);
    @(posedge clk); #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s literal read @%h: actual %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  // Run n cycles reading address a; ticks come from an LFSR plus a forced mask
  task automatic run(input int n, input logic [4:0] a, input logic [3:0] force_t);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(1, 0, a, 0);
      tick_src = lfsr[3:0] | force_t;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    cur_tag = "R1";
    rd_lit(5'h08, 16'h000A, "R1");
    rd_lit(5'h00, 16'h0000, "R1");
    rd_lit(5'h04, 16'h0000, "R1");
    rd_lit(5'h10, 16'h0000, "R1");
    rd_lit(5'h1C, 16'h0000, "R1");
    wr(5'h08, 16'hFFFF);
    rd_lit(5'h08, 16'h1FFF, "R1");

    // R2: up count on source 2, free running
    cur_tag = "R2";
    wr(5'h08, 16'h0046);
    run(40, 5'h04, 4'h0);
    wr(5'h08, 16'h0024);               // down, source 1
    run(30, 5'h04, 4'h0);

    // R3: disabled, all ticks high
    cur_tag = "R3";
    wr(5'h08, 16'h0042);
    run(20, 5'h04, 4'hF);

    // R4: periodic up reload, then free down wrap
    cur_tag = "R4";
    wr(5'h00, 16'hFFFA);
    wr(5'h08, 16'h008E);
    wr(5'h0C, 16'h0001);
    run(40, 5'h04, 4'h1);
    wr(5'h00, 16'h0003);
    wr(5'h08, 16'h008C);
    wr(5'h0C, 16'h0001);
    wr(5'h08, 16'h0004);
    run(12, 5'h04, 4'h1);
    wr(5'h08, 16'h0006);
    run(8, 5'h04, 4'h1);

    // R5: interrupt pending and clear
    cur_tag = "R5";
    wr(5'h0C, 16'h0001);
    run(4, 5'h1C, 4'h0);
    wr(5'h00, 16'h0004);
    wr(5'h08, 16'h000C);
    run(20, 5'h1C, 4'h1);
    wr(5'h0C, 16'h0001);
    run(6, 5'h1C, 4'h1);
    wr(5'h0C, 16'h0000);               // bit 0 clear: no effect
    run(4, 5'h1C, 4'h0);

    // R6: load writes landing on timeouts
    cur_tag = "R6";
    wr(5'h00, 16'h0002);
    wr(5'h08, 16'h000C);
    tick_src = 4'h1;
    for (int i = 0; i < 16; i++) begin
      wr(5'h00, 16'(i % 3));
      cyc(1, 0, 5'h00, 0);
    end
    run(10, 5'h04, 4'h1);

    // R7: clear with reload enabled and disabled
    cur_tag = "R7";
    wr(5'h00, 16'h1000);
    wr(5'h08, 16'h008E);
    run(10, 5'h04, 4'h1);
    wr(5'h0C, 16'h0001);
    run(6, 5'h04, 4'h1);
    wr(5'h08, 16'h000E);
    run(4, 5'h04, 4'h0);
    wr(5'h0C, 16'h0001);
    run(6, 5'h04, 4'h0);
    wr(5'h08, 16'h0086);
    wr(5'h0C, 16'h0001);
    run(6, 5'h04, 4'h0);

    // R8: capture on event line 5
    cur_tag = "R8";
    wr(5'h08, 16'h1506);
    run(5, 5'h04, 4'h1);
    evt_in = 16'h0020;
    run(2, 5'h1C, 4'h1);
    evt_in = 16'h0000;
    run(2, 5'h10, 4'h1);
    run(2, 5'h1C, 4'h1);
    evt_in = 16'h0020;
    cyc(1, 0, 5'h10, 0);               // read and capture in the same cycle
    evt_in = 16'h0000;
    run(2, 5'h1C, 4'h1);
    run(2, 5'h10, 4'h0);

    // R9: held level, unselected lines, capture disabled
    cur_tag = "R9";
    evt_in = 16'h0020;
    run(3, 5'h10, 4'h1);
    run(8, 5'h1C, 4'h1);
    run(2, 5'h10, 4'h1);
    evt_in = 16'hFFDF;
    run(4, 5'h10, 4'h1);
    run(2, 5'h1C, 4'h1);
    evt_in = 16'h0000;
    wr(5'h08, 16'h0506);
    run(2, 5'h10, 4'h1);
    evt_in = 16'h0020;
    run(3, 5'h10, 4'h1);
    run(2, 5'h1C, 4'h1);
    evt_in = 16'h0000;

    // R10: count readback delay under random ticks, direction change
    cur_tag = "R10";
    wr(5'h08, 16'h0006);
    run(30, 5'h04, 4'h0);
    wr(5'h08, 16'h0004);
    run(30, 5'h04, 4'h0);

    // R11: read-only writes ignored, unmapped and clear read zero
    cur_tag = "R11";
    wr(5'h04, 16'h5555);
    wr(5'h10, 16'hAAAA);
    wr(5'h1C, 16'h0003);
    run(2, 5'h10, 4'h0);
    run(2, 5'h1C, 4'h0);
    rd_lit(5'h14, 16'h0000, "R11");
    rd_lit(5'h0C, 16'h0000, "R11");
    rd_lit(5'h18, 16'h0000, "R11");
    cyc(0, 0, 5'h00, 0);
    run(4, 5'h04, 4'h0);

    cyc(0, 0, 5'h00, 0);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule